// File: doc/BRIEF.md
# Series Cell Bleed Balancer Selector

This block decides which cell of a small series stack of storage cells should have its bleed discharger switched on. It receives a complete set of digitized cell voltages as one beat on a valid/ready stream. With that set it reads two plain control values: how many cells are fitted, and a spread threshold in ADC counts. Among the fitted cells it finds the highest and the lowest voltage. When the gap between them is strictly larger than the threshold, it enables the discharger of the highest cell and no other. It re-evaluates only when a new set is accepted, so the enable cannot chatter between measurement sets.

A plain backup-mode input turns every discharger off in the same cycle. It also discards the held decision, so balancing resumes only after a new set arrives outside backup. A busy flag shows that a discharger is on.

The measurement stream accepts one beat per cycle. Ready is low only while reset is asserted and is held high at all other times. A beat transfers on any rising edge where valid and ready are both high. The block never applies back-pressure, so an upstream source may stream sets back to back.

Top module: `cbal_selector`

## Requirements
- R1: While reset is asserted, and immediately after it is released, all discharge enables and busy are 0. Ready is 0 while reset is asserted and 1 once it is released.
- R2: The held selection changes only on a rising edge where a set is accepted (valid and ready both high), or when backup mode clears it. Cell voltages, count and threshold presented without valid have no effect.
- R3: The enabled cell is the fitted cell with the highest voltage. When two or more fitted cells share that highest voltage, the one with the lowest index is chosen.
- R4: A cell is enabled only when the highest fitted voltage minus the lowest fitted voltage is strictly greater than the threshold. When the gap equals the threshold or is smaller, no cell is enabled.
- R5: Cells whose index (cell 0 in the least significant field of the voltage bus) is at or above the cell count are ignored. A count of 0 or 1 never enables a discharger, and a count above the number of cells is treated as all cells.
- R6: While backup mode is high, every enable is 0 in that same cycle. Sets accepted during backup select nothing. After backup falls, the enables stay 0 until a set is accepted outside backup.
- R7: At most one enable is high, and busy is high exactly when an enable is high.
- R8: The decision for an accepted set appears on the outputs right after the rising edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| meas_valid | input | 1 | A complete voltage set is offered |
| meas_ready | output | 1 | Set can be taken (high out of reset) |
| meas_volts | input | NUM_CELLS*VW | Cell voltages, cell i in bits [i*VW +: VW] |
| cell_count | input | CNT_W | Number of fitted cells, sampled with the set |
| spread_thresh | input | VW | Allowed spread in ADC counts, sampled with the set |
| backup_mode | input | 1 | Forces all dischargers off |
| bleed_en | output | NUM_CELLS | One-hot discharge enable per cell |
| busy | output | 1 | A discharger is on |

## Verification
An accepted set produces its result one register stage later, right after the accepting edge. Backup gating needs no edge: it acts in the same cycle. The bench drives and samples at falling edges. It checks a set's result at the falling edge after the accepting edge. It checks stability one full cycle later, after changing the unaccepted inputs. It checks the backup effect a short delay after raising the input, with no edge in between.

// File: rtl/cbal_pkg.sv
package cbal_pkg;
  localparam int DEF_CELLS = 4;
  localparam int DEF_VW    = 14;

  function automatic int idx_width(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/cbal_active_mask.sv
module cbal_active_mask #(
  parameter int NUM_CELLS = 4,
  parameter int CNT_W     = 3
) (
  input  logic [CNT_W-1:0]     cell_count,
  output logic [NUM_CELLS-1:0] active,
  output logic                 multi
);
  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_mask
    assign active[i] = (32'(cell_count) > i);
  end
  assign multi = (32'(cell_count) >= 2);
endmodule

// File: rtl/cbal_extrema.sv
module cbal_extrema #(
  parameter int NUM_CELLS = 4,
  parameter int VW        = 14,
  parameter int IDX_W     = 2
) (
  input  logic [NUM_CELLS*VW-1:0] volts,
  input  logic [NUM_CELLS-1:0]    active,
  output logic [VW-1:0]           max_v,
  output logic [VW-1:0]           min_v,
  output logic [IDX_W-1:0]        max_idx
);
  logic [VW-1:0]    run_max [0:NUM_CELLS];
  logic [VW-1:0]    run_min [0:NUM_CELLS];
  logic [IDX_W-1:0] run_idx [0:NUM_CELLS];

  assign run_max[0] = '0;
  assign run_min[0] = '1;
  assign run_idx[0] = '0;

  // Strict compare on a rising index keeps the lowest index on ties.
  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_chain
    logic [VW-1:0] v;
    logic          higher, lower;
    assign v      = volts[i*VW +: VW];
    assign higher = active[i] && (v > run_max[i]);
    assign lower  = active[i] && (v < run_min[i]);
    assign run_max[i+1] = higher ? v : run_max[i];
    assign run_idx[i+1] = higher ? IDX_W'(i) : run_idx[i];
    assign run_min[i+1] = lower  ? v : run_min[i];
  end

  assign max_v   = run_max[NUM_CELLS];
  assign min_v   = run_min[NUM_CELLS];
  assign max_idx = run_idx[NUM_CELLS];
endmodule

// File: rtl/cbal_pick.sv
module cbal_pick #(
  parameter int NUM_CELLS = 4,
  parameter int VW        = 14,
  parameter int IDX_W     = 2
) (
  input  logic [VW-1:0]        max_v,
  input  logic [VW-1:0]        min_v,
  input  logic [IDX_W-1:0]     max_idx,
  input  logic                 multi,
  input  logic [VW-1:0]        thresh,
  input  logic                 backup,
  output logic [NUM_CELLS-1:0] pick
);
  logic [VW-1:0] spread;
  logic          go;

  assign spread = max_v - min_v;
  assign go     = multi && !backup && (spread > thresh);

  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_onehot
    assign pick[i] = go && (max_idx == IDX_W'(i));
  end
endmodule

// File: rtl/cbal_selector.sv
module cbal_selector #(
  parameter int NUM_CELLS = cbal_pkg::DEF_CELLS,
  parameter int VW        = cbal_pkg::DEF_VW,
  parameter int CNT_W     = $clog2(NUM_CELLS + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    meas_valid,
  output logic                    meas_ready,
  input  logic [NUM_CELLS*VW-1:0] meas_volts,
  input  logic [CNT_W-1:0]        cell_count,
  input  logic [VW-1:0]           spread_thresh,
  input  logic                    backup_mode,
  output logic [NUM_CELLS-1:0]    bleed_en,
  output logic                    busy
);
  localparam int IDX_W = cbal_pkg::idx_width(NUM_CELLS);

  logic [NUM_CELLS-1:0] active;
  logic                 multi;
  logic [VW-1:0]        max_v, min_v;
  logic [IDX_W-1:0]     max_idx;
  logic [NUM_CELLS-1:0] pick;
  logic [NUM_CELLS-1:0] sel_q;
  logic                 accept;

  assign meas_ready = rst_n;
  assign accept     = meas_valid && meas_ready;

  cbal_active_mask #(.NUM_CELLS(NUM_CELLS), .CNT_W(CNT_W)) u_mask (
    .cell_count (cell_count),
    .active     (active),
    .multi      (multi)
  );

  cbal_extrema #(.NUM_CELLS(NUM_CELLS), .VW(VW), .IDX_W(IDX_W)) u_ext (
    .volts   (meas_volts),
    .active  (active),
    .max_v   (max_v),
    .min_v   (min_v),
    .max_idx (max_idx)
  );

  cbal_pick #(.NUM_CELLS(NUM_CELLS), .VW(VW), .IDX_W(IDX_W)) u_pick (
    .max_v   (max_v),
    .min_v   (min_v),
    .max_idx (max_idx),
    .multi   (multi),
    .thresh  (spread_thresh),
    .backup  (backup_mode),
    .pick    (pick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           sel_q <= '0;
    else if (backup_mode) sel_q <= '0;
    else if (accept)      sel_q <= pick;
  end

  assign bleed_en = backup_mode ? '0 : sel_q;
  assign busy     = |bleed_en;
endmodule

// File: rtl/cbal_selector_chk.sv
module cbal_selector_chk #(
  parameter int NUM_CELLS = 4,
  parameter int CNT_W     = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 meas_valid,
  input logic                 meas_ready,
  input logic [CNT_W-1:0]     cell_count,
  input logic                 backup_mode,
  input logic [NUM_CELLS-1:0] bleed_en,
  input logic                 busy
);
  assert_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bleed_en));

  assert_busy_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy == ($countones(bleed_en) == 1));

  assert_backup_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    backup_mode |-> (bleed_en == '0));

  assert_backup_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(backup_mode) |-> (bleed_en == '0));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(meas_valid && meas_ready) |=> ($stable(bleed_en) || bleed_en == '0));

  assert_single_cell_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_valid && meas_ready && 32'(cell_count) <= 1) |=> (bleed_en == '0));
endmodule

bind cbal_selector cbal_selector_chk #(.NUM_CELLS(NUM_CELLS), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .meas_valid  (meas_valid),
  .meas_ready  (meas_ready),
  .cell_count  (cell_count),
  .backup_mode (backup_mode),
  .bleed_en    (bleed_en),
  .busy        (busy)
);

// File: tb/tb_cbal_selector.sv
`timescale 1ns/1ps
module tb_cbal_selector;
  localparam int N  = 4;
  localparam int VW = 14;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          meas_valid = 1'b0;
  logic          meas_ready;
  logic [N*VW-1:0] meas_volts = '0;
  logic [CW-1:0] cell_count = '0;
  logic [VW-1:0] spread_thresh = '0;
  logic          backup_mode = 1'b0;
  logic [N-1:0]  bleed_en;
  logic          busy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cbal_selector dut (
    .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid), .meas_ready(meas_ready),
    .meas_volts(meas_volts), .cell_count(cell_count), .spread_thresh(spread_thresh),
    .backup_mode(backup_mode), .bleed_en(bleed_en), .busy(busy)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%0d expected=%0d", req, got, exp);
    end
  endtask

  function automatic int expect_sel(input int v0, input int v1, input int v2,
                                    input int v3, input int cnt, input int th);
    int v[4];
    int n, hi, lo, hi_i;
    v[0] = v0; v[1] = v1; v[2] = v2; v[3] = v3;
    n = (cnt > N) ? N : cnt;
    if (n < 2) return 0;
    hi = v[0]; lo = v[0]; hi_i = 0;
    for (int i = 1; i < n; i++) begin
      if (v[i] > hi) begin hi = v[i]; hi_i = i; end
      if (v[i] < lo) lo = v[i];
    end
    return (hi - lo > th) ? (1 << hi_i) : 0;
  endfunction

  function automatic logic [N*VW-1:0] pack(input int v0, input int v1,
                                           input int v2, input int v3);
    return {VW'(v3), VW'(v2), VW'(v1), VW'(v0)};
  endfunction

  task automatic send(input int v0, input int v1, input int v2, input int v3,
                      input int cnt, input int th);
    meas_volts    = pack(v0, v1, v2, v3);
    cell_count    = CW'(cnt);
    spread_thresh = VW'(th);
    meas_valid    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    meas_valid    = 1'b0;
  endtask

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int th_list[4];
    int e;
    th_list[0] = 0; th_list[1] = 4; th_list[2] = 5; th_list[3] = 10;

    // R1: state while reset is held
    repeat (3) @(negedge clk);
    check("R1 ready in reset", int'(meas_ready), 0);
    check("R1 enables in reset", int'(bleed_en), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", int'(meas_ready), 1);
    check("R1 enables after reset", int'(bleed_en), 0);
    check("R1 busy after reset", int'(busy), 0);

    // R3 R4 R5 R8 R7 R2: sweep over counts, thresholds and voltage patterns
    for (int cnt = 0; cnt < 8; cnt++) begin
      for (int t = 0; t < 4; t++) begin
        for (int code = 0; code < 256; code++) begin
          int a, b, c, d;
          a = 100 + 5 * (code & 3);
          b = 100 + 5 * ((code >> 2) & 3);
          c = 100 + 5 * ((code >> 4) & 3);
          d = 100 + 5 * ((code >> 6) & 3);
          e = expect_sel(a, b, c, d, cnt, th_list[t]);
          send(a, b, c, d, cnt, th_list[t]);
          check("R3/R4/R5/R8 selection", int'(bleed_en), e);
          check("R7 busy", int'(busy), (e != 0) ? 1 : 0);
          // R2: inputs without valid change nothing
          meas_volts    = pack(d + 40, c, b, a + 40);
          cell_count    = CW'(7 - cnt);
          spread_thresh = '0;
          @(posedge clk);
          @(negedge clk);
          check("R2 hold without valid", int'(bleed_en), e);
        end
      end
    end

    // R6: backup forces off at once, discards selection
    send(300, 100, 100, 100, 4, 10);
    check("R3 highest cell0", int'(bleed_en), 1);
    backup_mode = 1'b1;
    #1;
    check("R6 same-cycle off", int'(bleed_en), 0);
    check("R6 busy off", int'(busy), 0);
    @(negedge clk);
    send(100, 100, 100, 400, 4, 10);
    check("R6 set in backup ignored", int'(bleed_en), 0);
    backup_mode = 1'b0;
    #1;
    check("R6 stays off after exit", int'(bleed_en), 0);
    @(posedge clk);
    @(negedge clk);
    check("R6 off until new set", int'(bleed_en), 0);
    send(100, 100, 100, 400, 4, 10);
    check("R6 resumes after new set", int'(bleed_en), 8);

    // R4: large values, spread exactly at and one above threshold
    send(16383, 16000, 16383, 16383, 4, 383);
    check("R4 equal spread off", int'(bleed_en), 0);
    send(16383, 16000, 16383, 16383, 4, 382);
    check("R3 tie picks lowest index", int'(bleed_en), 1);
    // R5: count above cell total acts as all cells
    send(0, 0, 0, 9000, 7, 10);
    check("R5 count over total", int'(bleed_en), 8);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule